// File: doc/BRIEF.md
# Three-Channel Reload Timer Unit

This block is a timer peripheral with up to three reload down-counter channels behind one flat, word-addressed register window. A bus master programs each channel's reload value, current count and control word. It starts or stops every channel through one shared start register. A one-bit output-control register is also available. Each channel raises its own interrupt line when its count underflows and the channel's interrupt enable is set.

Two parameters select the optional features. `HAS_CH2` includes the third channel, which is the only one with a capture register. `HAS_OUTCTL` includes the output-control register. When a feature is absent, any access to it is rejected and reported on the error output. Every part of the block runs on one clock with one synchronous active-high reset. Reads and error reports come out registered, one cycle after the request.

Top module: `tmr3_unit`

## Requirements
- R1: Byte offset 0x00 is the output-control register. Only bit 0 is stored, other bits read as zero, and it resets to 0.
- R2: Byte offset 0x04 is the start register. It reads back the full word last accepted, and it resets to zero. Bit i set runs channel i.
- R3: Channel bank bases are 0x08 (channel 0), 0x14 (channel 1) and 0x20 (channel 2). Inside a bank the word at +0x0 is the reload value, +0x4 is the count and +0x8 is the control word. Channel 2 alone has a read/write capture register at +0xC.
- R4: A running channel decrements its count by one every clock. When its count is zero it loads the reload value and sets its underflow flag (control bit 8). A write to the count takes priority over counting.
- R5: Each interrupt output goes high one cycle after that channel's underflow flag and interrupt enable (control bit 5) are both set.
- R6: A control write with bit 8 clear clears the underflow flag. A control write with bit 8 set leaves the flag unchanged.
- R7: Clearing a start bit freezes that channel's count. Setting the bit again resumes counting from the frozen value.
- R8: A read of an unmapped or misaligned offset returns zero and pulses the error output for one cycle. A write there changes no state and pulses the error output.
- R9: With `HAS_CH2`=0, accesses at 0x20 and above are errors. A start write with bit 2 set is an error and leaves the start register unchanged. Interrupt line 2 stays low.
- R10: With `HAS_OUTCTL`=0, an access to offset 0x00 is an error.
- R11: After reset, every reload value and count is all ones, and every control word and the capture register are zero.
- R12: Read data and the error pulse appear in the cycle after the read or write request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | AW | Byte offset into the register window |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| err | output | 1 | One-cycle pulse on an illegal access |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The bench targets the reload cycle exactly. A counter that is off by one would raise its interrupt a cycle early or late. A counter that skips the reload would show a wrong count after underflow. Stop and resume is checked by exact count values: a design that reloads on restart, or that keeps counting while stopped, reads back a different number. The reduced build is checked to reject start bit 2 without disturbing the start register. Unmapped and misaligned reads must return zero with an error pulse; a design that leaks stale data, or that drops the pulse, fails those checks.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int unsigned OFS_OUTCTL = 8'h00;
  localparam int unsigned OFS_START  = 8'h04;
  localparam int unsigned BASE_CH0   = 8'h08;
  localparam int unsigned BASE_CH1   = 8'h14;
  localparam int unsigned BASE_CH2   = 8'h20;
  localparam int unsigned END_CH2    = 8'h30;

  localparam logic [1:0] LOC_RELOAD = 2'd0;
  localparam logic [1:0] LOC_COUNT  = 2'd1;
  localparam logic [1:0] LOC_CTRL   = 2'd2;
  localparam logic [1:0] LOC_CAP    = 2'd3;

  localparam int unsigned IE_BIT = 5;
  localparam int unsigned UF_BIT = 8;
  localparam int unsigned NCH_MAX = 3;
endpackage

// File: rtl/tmr3_decode.sv
module tmr3_decode #(
  parameter int AW         = 8,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic          sel_outctl,
  output logic          sel_start,
  output logic [2:0]    sel_ch,
  output logic [1:0]    loc
);
  import tmr3_pkg::*;

  logic          aligned;
  logic [AW-1:0] rel;

  always_comb begin
    aligned    = (addr[1:0] == 2'b00);
    sel_outctl = 1'b0;
    sel_start  = 1'b0;
    sel_ch     = 3'b000;
    rel        = '0;
    if (aligned) begin
      if (HAS_OUTCTL && addr == AW'(OFS_OUTCTL)) sel_outctl = 1'b1;
      else if (addr == AW'(OFS_START)) sel_start = 1'b1;
      else if (addr >= AW'(BASE_CH0) && addr < AW'(BASE_CH1)) begin
        sel_ch[0] = 1'b1;
        rel       = addr - AW'(BASE_CH0);
      end else if (addr >= AW'(BASE_CH1) && addr < AW'(BASE_CH2)) begin
        sel_ch[1] = 1'b1;
        rel       = addr - AW'(BASE_CH1);
      end else if (HAS_CH2 && addr >= AW'(BASE_CH2) && addr < AW'(END_CH2)) begin
        sel_ch[2] = 1'b1;
        rel       = addr - AW'(BASE_CH2);
      end
    end
    loc = rel[3:2];
    hit = sel_outctl | sel_start | (|sel_ch);
  end
endmodule

// File: rtl/tmr3_chan.sv
module tmr3_chan #(
  parameter int DW      = 32,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wr,
  input  logic [1:0]    loc,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_o
);
  import tmr3_pkg::*;

  logic [DW-1:0] reload_q, count_q, cap_q;
  logic          ie_q, flag_q;
  logic          wr_reload, wr_count, wr_ctrl, wr_cap, underflow;

  assign wr_reload = wr && (loc == LOC_RELOAD);
  assign wr_count  = wr && (loc == LOC_COUNT);
  assign wr_ctrl   = wr && (loc == LOC_CTRL);
  assign wr_cap    = wr && (loc == LOC_CAP) && HAS_CAP;
  assign underflow = run && !wr_count && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      count_q  <= '1;
      cap_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_cap)    cap_q    <= wdata;
      if (wr_count)       count_q <= wdata;
      else if (underflow) count_q <= reload_q;
      else if (run)       count_q <= count_q - 1'b1;
      if (wr_ctrl) ie_q <= wdata[IE_BIT];
      flag_q <= underflow | (flag_q & ~(wr_ctrl & ~wdata[UF_BIT]));
      irq_o  <= flag_q & ie_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (loc)
      LOC_RELOAD: rdata = reload_q;
      LOC_COUNT:  rdata = count_q;
      LOC_CTRL: begin
        rdata[IE_BIT] = ie_q;
        rdata[UF_BIT] = flag_q;
      end
      default:    rdata = HAS_CAP ? cap_q : '0;
    endcase
  end

  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run && !wr && count_q == '0) |=> (count_q == $past(reload_q)) && flag_q); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr) |=> $stable(count_q)); // R7
endmodule

// File: rtl/tmr3_unit.sv
module tmr3_unit #(
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [2:0]    irq
);
  import tmr3_pkg::*;

  localparam int NCH = HAS_CH2 ? 3 : 2;

  logic          hit, sel_outctl, sel_start, start_bad;
  logic [2:0]    sel_ch;
  logic [1:0]    loc;
  logic [DW-1:0] start_q;
  logic          outctl_q;
  logic [DW-1:0] ch_rdata [NCH_MAX];
  logic [DW-1:0] mux_rdata;

  tmr3_decode #(.AW(AW), .HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr(addr), .hit(hit), .sel_outctl(sel_outctl), .sel_start(sel_start),
    .sel_ch(sel_ch), .loc(loc)
  );

  for (genvar i = 0; i < NCH_MAX; i++) begin : g_ch
    if (i < NCH) begin : g_on
      tmr3_chan #(.DW(DW), .HAS_CAP(i == 2)) u_chan (
        .clk(clk), .rst(rst), .run(start_q[i]), .wr(wr_en && sel_ch[i]),
        .loc(loc), .wdata(wdata), .rdata(ch_rdata[i]), .irq_o(irq[i])
      );
    end else begin : g_off
      assign ch_rdata[i] = '0;
      assign irq[i]      = 1'b0;
    end
  end

  assign start_bad = sel_start && !HAS_CH2 && wdata[2];

  always_comb begin
    mux_rdata = '0;
    if (sel_outctl)     mux_rdata[0] = outctl_q;
    else if (sel_start) mux_rdata = start_q;
    else if (sel_ch[0]) mux_rdata = ch_rdata[0];
    else if (sel_ch[1]) mux_rdata = ch_rdata[1];
    else if (sel_ch[2]) mux_rdata = ch_rdata[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      outctl_q <= 1'b0;
      rdata    <= '0;
      err      <= 1'b0;
    end else begin
      if (wr_en && sel_start && !start_bad) start_q <= wdata;
      if (wr_en && sel_outctl) outctl_q <= wdata[0];
      if (rd_en) rdata <= hit ? mux_rdata : '0;
      err <= (rd_en && !hit) || (wr_en && (!hit || start_bad));
    end
  end

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> err && (rdata == '0)); // R8
  AST_NO_CH2_START: assert property (@(posedge clk) disable iff (rst)
    (HAS_CH2 || !start_q[2])); // R9
endmodule

// File: tb/sim_tmr3_unit.sv
module sim_tmr3_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  wr_en, rd_en;
  logic [7:0]  addr  [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic [1:0]  err;
  logic [2:0]  irq0, irq1;
  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] rv;
  logic        le;

  always #4 clk = ~clk;

  tmr3_unit u0 (.clk(clk), .rst(rst), .wr_en(wr_en[0]), .rd_en(rd_en[0]),
    .addr(addr[0]), .wdata(wdata[0]), .rdata(rdata[0]), .err(err[0]), .irq(irq0));
  tmr3_unit #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) u1 (.clk(clk), .rst(rst),
    .wr_en(wr_en[1]), .rd_en(rd_en[1]), .addr(addr[1]), .wdata(wdata[1]),
    .rdata(rdata[1]), .err(err[1]), .irq(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input int u, input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en[u] = w; rd_en[u] = !w; addr[u] = a; wdata[u] = d;
    @(posedge clk);
    @(negedge clk);
    wr_en[u] = 1'b0; rd_en[u] = 1'b0;
    rv = rdata[u]; le = err[u];
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [31:0] d);
    return (a == 8'h00) ? (d & 32'h1) : d;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] amap [6];
    logic [7:0] bad  [4];
    amap = '{8'h00, 8'h04, 8'h08, 8'h14, 8'h20, 8'h2C};
    bad  = '{8'h30, 8'h44, 8'h06, 8'h11};
    wr_en = '0; rd_en = '0;
    addr = '{8'h0, 8'h0}; wdata = '{32'h0, 32'h0};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    bus(0, 0, 8'h04, 0); chk("R2 start reset", rv, 32'h0);
    bus(0, 0, 8'h00, 0); chk("R1 outctl reset", rv, 32'h0);
    bus(0, 0, 8'h0C, 0); chk("R11 count reset", rv, 32'hFFFF_FFFF);
    bus(0, 0, 8'h20, 0); chk("R11 reload reset", rv, 32'hFFFF_FFFF);
    bus(0, 0, 8'h10, 0); chk("R11 ctrl reset", rv, 32'h0);
    bus(0, 0, 8'h2C, 0); chk("R11 capture reset", rv, 32'h0);
    chk("R5 irq reset", {29'd0, irq0}, 32'h0);

    for (int n = 0; n < 150; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = amap[$urandom_range(0, 5)];
      d = $urandom;
      bus(0, 1, a, d);
      chk("R12 write no err", {31'd0, le}, 32'h0);
      bus(0, 0, a, 0);
      chk("R3 readback", rv, exp_rd(a, d));
      if (n % 10 == 0) begin
        bus(0, 0, bad[$urandom_range(0, 3)], 0);
        chk("R8 bad read data", rv, 32'h0);
        chk("R8 bad read err", {31'd0, le}, 32'h1);
      end
    end
    bus(0, 1, 8'h04, 32'h0);

    bus(0, 1, 8'h00, 32'hFFFF_FFFE); bus(0, 0, 8'h00, 0); chk("R1 bit0 only", rv, 32'h0);
    bus(0, 1, 8'h00, 32'hFFFF_FFFF); bus(0, 0, 8'h00, 0); chk("R1 bit0 set", rv, 32'h1);

    // R4/R5: ch0 count 3, reload 5, irq enabled
    bus(0, 1, 8'h08, 32'd5); bus(0, 1, 8'h0C, 32'd3); bus(0, 1, 8'h10, 32'h20);
    bus(0, 1, 8'h04, 32'h1);
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R5 irq not yet", {29'd0, irq0}, 32'h0);
    @(negedge clk); chk("R5 irq rises", {29'd0, irq0}, 32'h1);
    bus(0, 1, 8'h04, 32'h0);
    bus(0, 0, 8'h0C, 0); chk("R4 reloaded count", rv, 32'd2);
    bus(0, 0, 8'h10, 0); chk("R4 flag set", rv, 32'h120);
    bus(0, 1, 8'h10, 32'h120); bus(0, 0, 8'h10, 0); chk("R6 write 1 keeps flag", rv, 32'h120);
    bus(0, 1, 8'h10, 32'h20);
    @(negedge clk); chk("R6 irq drops", {29'd0, irq0}, 32'h0);
    bus(0, 0, 8'h10, 0); chk("R6 flag cleared", rv, 32'h20);

    // R7: ch1 stop and resume
    bus(0, 1, 8'h14, 32'hFFFF); bus(0, 1, 8'h18, 32'd100);
    bus(0, 1, 8'h04, 32'h2); repeat (8) @(negedge clk); bus(0, 1, 8'h04, 32'h0);
    bus(0, 0, 8'h18, 0); chk("R7 counted 10", rv, 32'd90);
    repeat (5) @(negedge clk);
    bus(0, 0, 8'h18, 0); chk("R7 frozen", rv, 32'd90);
    bus(0, 1, 8'h04, 32'h2); repeat (8) @(negedge clk); bus(0, 1, 8'h04, 32'h0);
    bus(0, 0, 8'h18, 0); chk("R7 resumed", rv, 32'd80);

    // R5 on ch2
    bus(0, 1, 8'h20, 32'd0); bus(0, 1, 8'h24, 32'd0); bus(0, 1, 8'h28, 32'h20);
    bus(0, 1, 8'h04, 32'h4);
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R5 ch2 irq", {29'd0, irq0}, 32'h4);
    bus(0, 1, 8'h04, 32'h0);

    // R8 bad write leaves state
    bus(0, 1, 8'h05, 32'h7); chk("R8 bad write err", {31'd0, le}, 32'h1);
    bus(0, 0, 8'h04, 0); chk("R8 start untouched", rv, 32'h0);

    // reduced build
    bus(1, 0, 8'h20, 0); chk("R9 ch2 read err", {31'd0, le}, 32'h1);
    chk("R9 ch2 read data", rv, 32'h0);
    bus(1, 1, 8'h04, 32'h3); chk("R9 legal start", {31'd0, le}, 32'h0);
    bus(1, 1, 8'h04, 32'h7); chk("R9 start bit2 err", {31'd0, le}, 32'h1);
    bus(1, 0, 8'h04, 0); chk("R9 start unchanged", rv, 32'h3);
    bus(1, 1, 8'h04, 32'h0);
    chk("R9 irq2 low", {31'd0, irq1[2]}, 32'h0);
    bus(1, 0, 8'h00, 0); chk("R10 outctl absent", {31'd0, le}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule